// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block sits between a processor core and an 8-bit external memory bus on which the low address byte and the data byte share one set of pins. The core hands over one request at a time: a program fetch, a data read or a data write. The block then runs a complete bus cycle. Every time unit in that cycle is one clock period, called a phase. The low address goes out on the shared pins and an address-latch pulse marks it, so an external latch can capture it. The pins are then either released for incoming data or driven with write data. The upper address bits go out on their own pins during the whole cycle. One active-low strobe per access type tells the memory when to respond.

Program fetches use a 17-bit address, and their top bit has a pin of its own. Data accesses use 16 bits and leave that pin undriven. A wait input from slow data memory can lengthen the strobe one phase at a time. Fetch cycles ignore it. A separate float input removes every address and data driver from the pins while it is high. It does not change the latch pulse, the strobes or the timing.

Top module: `xbus_seq`

## Requirements
- R1: After reset and whenever no cycle is in progress, `busIdle` is high, `ale` is low, `fetchN`, `rdN` and `wrN` are high, `ack` is low, and the output enables `adOutEn`, `addrHiEn` and `addr16En` are low.
- R2: `reqKind` is encoded as 00 for a fetch, 01 for a read and 10 for a write. The block takes a request only in a phase where `busIdle` and `reqValid` are both high. A request with code 11 is ignored and leaves the bus idle.
- R3: In the two phases that follow acceptance, `ale` is high. During those two phases and the one phase after `ale` falls, `adOut` carries address bits 7:0.
- R4: Exactly one strobe is asserted (driven low), and it matches the kind: `fetchN` for code 00, `rdN` for 01, `wrN` for 10. The strobe becomes active one phase after `ale` falls and lasts two phases when it is not stretched. `ale` and the strobes are never active in the same phase.
- R5: `addrHi` carries address bits 15:8 from the first `ale` phase to one phase after the strobe ends. This places the upper address three phases ahead of the strobe.
- R6: Only fetch cycles enable `addr16`, which carries address bit 16 for the same span as `addrHi`. Read and write cycles keep `addr16En` low.
- R7: On a write, `adOut` carries the write data from the first strobe phase to one phase after `wrN` returns high.
- R8: On a read or a fetch, the shared pins are not driven while the strobe is active. `adIn` is sampled at the clock edge that ends the strobe. That value appears on `rdData` together with a one-phase `ack` in the phase that follows the strobe.
- R9: For reads and writes, `waitReq` is sampled in the last strobe phase. Each phase in which it is sampled high adds one strobe phase. `waitReq` has no effect in any other phase and no effect at all on fetches.
- R10: While `floatPins` is high, `adOutEn`, `addrHiEn` and `addr16En` are low. `floatPins` does not change `ale`, the strobes, `ack` or the phase count of the cycle.
- R11: `ack` marks the final phase of every cycle, including writes. The bus is idle in the next phase, so only one cycle is ever in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase clock; one period per phase |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Core request valid |
| reqKind | input | 2 | Access kind: 00 fetch, 01 read, 10 write |
| reqAddr | input | 17 | Request address; bit 16 used by fetches only |
| reqWrData | input | 8 | Write data |
| busIdle | output | 1 | Bus idle; request accepted this phase if valid |
| ack | output | 1 | One-phase completion pulse |
| rdData | output | 8 | Data sampled from the bus at strobe release |
| waitReq | input | 1 | External wait request for data accesses |
| floatPins | input | 1 | Forces address/data pin drivers off |
| adIn | input | 8 | Shared pins, input side |
| adOut | output | 8 | Shared pins, output value |
| adOutEn | output | 1 | Shared pins driver enable |
| addrHi | output | 8 | Upper address bits 15:8 |
| addrHiEn | output | 1 | Upper address driver enable |
| addr16 | output | 1 | Address bit 16 (fetch only) |
| addr16En | output | 1 | Address bit 16 driver enable |
| ale | output | 1 | Address latch pulse, active high |
| fetchN | output | 1 | Program fetch strobe, active low |
| rdN | output | 1 | Data read strobe, active low |
| wrN | output | 1 | Data write strobe, active low |

## Verification
The assertions assume that `floatPins` is the only input that can take away a pin driver. They also assume that no core request arrives with a reserved kind except as a deliberate test of that code. The stimulus follows both assumptions. A request is raised only in a phase where `busIdle` is high and is dropped right after it is taken. `waitReq` is held high from the first latch phase onward, so the stretch that results comes only from the phases in which it is sampled. `adIn` changes every phase, so the bench can see at which edge the read value was sampled.

// File: rtl/xbus_seq_pkg.sv
package xbus_seq_pkg;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_READ  = 2'd1,
    KIND_WRITE = 2'd2,
    KIND_RSVD  = 2'd3
  } kind_t;

  typedef struct packed {
    logic loadReq;    // capture request fields
    logic captureRd;  // sample shared pins into read register
    logic driveLo;    // low address on shared pins
    logic driveWr;    // write data on shared pins
    logic active;     // a bus cycle is in progress
    logic isFetch;    // current cycle is a program fetch
  } ctl_t;

endpackage

// File: rtl/xbus_seq_ctrl.sv
module xbus_seq_ctrl
  import xbus_seq_pkg::*;
#(
  parameter int ALE_PH = 2,
  parameter int STB_PH = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqKind,
  input  logic       waitReq,
  output ctl_t       ctl,
  output logic       busIdle,
  output logic       ale,
  output logic       fetchN,
  output logic       rdN,
  output logic       wrN,
  output logic       ack
);

  localparam int MAX_PH = (ALE_PH > STB_PH) ? ALE_PH : STB_PH;
  localparam int CNT_W  = $clog2(MAX_PH + 1);
  localparam logic [CNT_W-1:0] ALE_LAST = CNT_W'(ALE_PH - 1);
  localparam logic [CNT_W-1:0] STB_LAST = CNT_W'(STB_PH - 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALE,
    ST_AHOLD,
    ST_STB,
    ST_TAIL
  } state_t;

  state_t            state, stateNext;
  logic [CNT_W-1:0]  cnt, cntNext;
  kind_t             kind;
  logic              reqOk, stbOn, stbLast, stretch;

  assign reqOk   = reqValid && (kind_t'(reqKind) != KIND_RSVD);
  assign stbOn   = (state == ST_STB);
  assign stbLast = (cnt == STB_LAST);
  assign stretch = (kind != KIND_FETCH) && waitReq;

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    case (state)
      ST_IDLE: begin
        if (reqOk) begin
          stateNext = ST_ALE;
          cntNext   = '0;
        end
      end
      ST_ALE: begin
        if (cnt == ALE_LAST) begin
          stateNext = ST_AHOLD;
          cntNext   = '0;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      ST_AHOLD: begin
        stateNext = ST_STB;
        cntNext   = '0;
      end
      ST_STB: begin
        if (stbLast) begin
          if (!stretch) stateNext = ST_TAIL;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      ST_TAIL:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      kind  <= KIND_FETCH;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
      if (ctl.loadReq) kind <= kind_t'(reqKind);
    end
  end

  always_comb begin
    ctl.loadReq   = (state == ST_IDLE) && reqOk;
    ctl.captureRd = stbOn && stbLast && !stretch && (kind != KIND_WRITE);
    ctl.driveLo   = (state == ST_ALE) || (state == ST_AHOLD);
    ctl.driveWr   = (kind == KIND_WRITE) && (stbOn || (state == ST_TAIL));
    ctl.active    = (state != ST_IDLE);
    ctl.isFetch   = (kind == KIND_FETCH);
  end

  assign busIdle = (state == ST_IDLE);
  assign ale     = (state == ST_ALE);
  assign fetchN  = !(stbOn && (kind == KIND_FETCH));
  assign rdN     = !(stbOn && (kind == KIND_READ));
  assign wrN     = !(stbOn && (kind == KIND_WRITE));
  assign ack     = (state == ST_TAIL);

endmodule

// File: rtl/xbus_seq_dpath.sv
module xbus_seq_dpath
  import xbus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctl_t                ctl,
  input  logic [ADDR_W:0]     reqAddr,
  input  logic [DATA_W-1:0]   reqWrData,
  input  logic                floatPins,
  input  logic [DATA_W-1:0]   adIn,
  output logic [DATA_W-1:0]   rdData,
  output logic [DATA_W-1:0]   adOut,
  output logic                adOutEn,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic                addrHiEn,
  output logic                addr16,
  output logic                addr16En
);

  localparam int FULL_W = ADDR_W + 1;

  logic [FULL_W-1:0] addrReg;
  logic [DATA_W-1:0] wrReg;
  logic [DATA_W-1:0] rdReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      wrReg   <= '0;
      rdReg   <= '0;
    end else begin
      if (ctl.loadReq) begin
        addrReg <= reqAddr;
        wrReg   <= reqWrData;
      end
      if (ctl.captureRd) rdReg <= adIn;
    end
  end

  assign rdData   = rdReg;
  assign adOut    = ctl.driveLo ? addrReg[DATA_W-1:0] : wrReg;
  assign adOutEn  = (ctl.driveLo || ctl.driveWr) && !floatPins;
  assign addrHi   = addrReg[ADDR_W-1:DATA_W];
  assign addrHiEn = ctl.active && !floatPins;
  assign addr16   = addrReg[ADDR_W] && ctl.isFetch;
  assign addr16En = ctl.active && ctl.isFetch && !floatPins;

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int ALE_PH = 2,
  parameter int STB_PH = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic [1:0]               reqKind,
  input  logic [ADDR_W:0]          reqAddr,
  input  logic [DATA_W-1:0]        reqWrData,
  output logic                     busIdle,
  output logic                     ack,
  output logic [DATA_W-1:0]        rdData,
  input  logic                     waitReq,
  input  logic                     floatPins,
  input  logic [DATA_W-1:0]        adIn,
  output logic [DATA_W-1:0]        adOut,
  output logic                     adOutEn,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic                     addrHiEn,
  output logic                     addr16,
  output logic                     addr16En,
  output logic                     ale,
  output logic                     fetchN,
  output logic                     rdN,
  output logic                     wrN
);

  ctl_t ctl;

  xbus_seq_ctrl #(.ALE_PH(ALE_PH), .STB_PH(STB_PH)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .waitReq(waitReq), .ctl(ctl), .busIdle(busIdle), .ale(ale),
    .fetchN(fetchN), .rdN(rdN), .wrN(wrN), .ack(ack)
  );

  xbus_seq_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr),
    .reqWrData(reqWrData), .floatPins(floatPins), .adIn(adIn),
    .rdData(rdData), .adOut(adOut), .adOutEn(adOutEn), .addrHi(addrHi),
    .addrHiEn(addrHiEn), .addr16(addr16), .addr16En(addr16En)
  );

endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk (
  input logic clk,
  input logic rstN,
  input logic busIdle,
  input logic ack,
  input logic floatPins,
  input logic adOutEn,
  input logic addrHiEn,
  input logic addr16En,
  input logic ale,
  input logic fetchN,
  input logic rdN,
  input logic wrN
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    busIdle |-> (!ale && fetchN && rdN && wrN && !adOutEn && !addrHiEn && !ack)); // R1

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $countones({~fetchN, ~rdN, ~wrN}) <= 1); // R4

  AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> (fetchN && rdN && wrN)); // R4

  AST_LO_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(ale) && !floatPins) |-> adOutEn); // R3

  AST_ADDR16_FETCH_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    addr16En |-> (rdN && wrN)); // R6

  AST_WR_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(wrN) && !floatPins) |-> adOutEn); // R7

  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (!fetchN || !rdN) |-> !adOutEn); // R8

  AST_ACK_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    ack |-> !($past(fetchN) && $past(rdN) && $past(wrN))); // R8

  AST_FETCH_NO_STRETCH: assert property (@(posedge clk) disable iff (!rstN)
    (!fetchN && $past(!fetchN)) |=> fetchN); // R9

  AST_FLOAT_OFF: assert property (@(posedge clk) disable iff (!rstN)
    floatPins |-> (!adOutEn && !addrHiEn && !addr16En)); // R10

  AST_ACK_THEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> busIdle); // R11

endmodule

bind xbus_seq xbus_seq_chk chk_i (
  .clk(clk), .rstN(rstN), .busIdle(busIdle), .ack(ack),
  .floatPins(floatPins), .adOutEn(adOutEn), .addrHiEn(addrHiEn),
  .addr16En(addr16En), .ale(ale), .fetchN(fetchN), .rdN(rdN), .wrN(wrN)
);

// File: tb/xbus_seq_tb.sv
module xbus_seq_tb_top;

  localparam int CLK_NS = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqKind = 2'd0;
  logic [16:0] reqAddr = '0;
  logic [7:0]  reqWrData = '0;
  logic        waitReq = 1'b0;
  logic        floatPins = 1'b0;
  logic [7:0]  adIn = '0;
  logic        busIdle, ack, adOutEn, addrHiEn, addr16, addr16En;
  logic        ale, fetchN, rdN, wrN;
  logic [7:0]  rdData, adOut, addrHi;

  int vectors = 0;
  int misses  = 0;

  always #(CLK_NS/2) clk = ~clk;

  xbus_seq dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqWrData(reqWrData), .busIdle(busIdle), .ack(ack),
    .rdData(rdData), .waitReq(waitReq), .floatPins(floatPins), .adIn(adIn),
    .adOut(adOut), .adOutEn(adOutEn), .addrHi(addrHi), .addrHiEn(addrHiEn),
    .addr16(addr16), .addr16En(addr16En), .ale(ale), .fetchN(fetchN),
    .rdN(rdN), .wrN(wrN)
  );

  task automatic chk(input string tag, input int actual, input int expected);
    vectors++;
    if (actual != expected) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, actual, expected, $time);
    end
  endtask

  task automatic chkIdle(input string tag);
    chk({tag, " busIdle"}, int'(busIdle), 1);
    chk({tag, " ale"}, int'(ale), 0);
    chk({tag, " strobes"}, int'({fetchN, rdN, wrN}), 7);
    chk({tag, " ack"}, int'(ack), 0);
    chk({tag, " enables"}, int'({adOutEn, addrHiEn, addr16En}), 0);
  endtask

  // One full bus cycle; expectations derived from the requirements.
  task automatic doTxn(input int kind, input logic [16:0] addr, input logic [7:0] wd,
                       input int waits, input int floatMode);
    int wd2, tEnd;
    logic [7:0] pat;
    pat  = addr[7:0] ^ 8'h5A;
    wd2  = (kind == 0) ? 0 : waits;
    tEnd = 6 + wd2;
    @(posedge clk); #2;
    reqValid = 1'b1; reqKind = 2'(kind); reqAddr = addr; reqWrData = wd;
    waitReq = 1'b0; floatPins = 1'b0;
    #2 chk("R2 idle before request", int'(busIdle), 1);
    for (int k = 1; k <= tEnd + 1; k++) begin
      bit expAle, expLo, expStb, expAck, expIdle, expAct, fl, expDrv;
      @(posedge clk); #2;
      reqValid  = 1'b0;
      waitReq   = (k >= 1 && k <= 4 + waits);
      fl        = (floatMode != 0) && (k % 3 == 1);
      floatPins = fl;
      adIn      = pat ^ 8'(k);
      #2;
      expAle  = (k <= 2);
      expLo   = (k <= 3);
      expStb  = (k >= 4 && k <= 5 + wd2);
      expAck  = (k == tEnd);
      expIdle = (k > tEnd);
      expAct  = (k <= tEnd);
      expDrv  = expLo || (kind == 2 && k >= 4 && k <= tEnd);
      chk("R3 ale", int'(ale), int'(expAle));
      chk("R4 fetchN", int'(fetchN), int'(!(expStb && kind == 0)));
      chk("R4 rdN R9", int'(rdN), int'(!(expStb && kind == 1)));
      chk("R4 wrN R9", int'(wrN), int'(!(expStb && kind == 2)));
      chk("R11 ack", int'(ack), int'(expAck));
      chk("R11 busIdle", int'(busIdle), int'(expIdle));
      chk("R7 R8 R10 adOutEn", int'(adOutEn), int'(expDrv && !fl));
      if (expDrv && !fl)
        chk(expLo ? "R3 adOut addr" : "R7 adOut data", int'(adOut),
            expLo ? int'(addr[7:0]) : int'(wd));
      chk("R5 R10 addrHiEn", int'(addrHiEn), int'(expAct && !fl));
      if (expAct && !fl) chk("R5 addrHi", int'(addrHi), int'(addr[15:8]));
      chk("R6 addr16En", int'(addr16En), int'(expAct && kind == 0 && !fl));
      if (expAct && kind == 0 && !fl) chk("R6 addr16", int'(addr16), int'(addr[16]));
      if (expAck && kind != 2)
        chk("R8 rdData", int'(rdData), int'(pat ^ 8'(5 + wd2)));
    end
    waitReq = 1'b0; floatPins = 1'b0;
  endtask

  initial begin
    #(CLK_NS * 150000);
    misses++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    logic [16:0] addrs [3];
    addrs[0] = 17'h00000; addrs[1] = 17'h1A5C3; addrs[2] = 17'h0FFFF;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    #2 chkIdle("R1 reset");
    // Reserved kind code 11 must leave the bus idle (R2)
    @(posedge clk); #2;
    reqValid = 1'b1; reqKind = 2'd3; reqAddr = 17'h12345;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #2;
      chkIdle("R2 reserved");
    end
    reqValid = 1'b0;
    for (int kind = 0; kind < 3; kind++)
      for (int w = 0; w < 4; w++)
        for (int fm = 0; fm < 2; fm++)
          for (int a = 0; a < 3; a++)
            doTxn(kind, addrs[a] ^ 17'(w * 17 + fm), 8'(8'hC3 ^ (kind * 37 + a)), w, fm);
    @(posedge clk); #4;
    chkIdle("R1 final");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule